// File: doc/BRIEF.md
# Bulk/Interrupt IN Endpoint Transmitter

This block is the device-side engine for a single bulk or interrupt IN endpoint. Firmware pushes payload bytes into a local byte FIFO, then announces a transfer by pulsing a start strobe with the total transfer length and the largest packet the endpoint may send. Each time the host issues an IN token to the endpoint, the block answers with one of four responses. It sends a data packet tagged DATA0 or DATA1 and streams its bytes one per clock. It answers NAK when nothing is ready, or STALL when firmware has halted the endpoint. After a data packet it waits for the host's verdict: an ACK commits the bytes and moves the transfer forward, a timeout rewinds so that the same bytes go out again.

A transfer is cut into packets of the maximum size, and the last packet is shorter and holds whatever remains. A transfer whose length is an exact multiple of the maximum size, including a length of zero, ends with an empty packet, because only a short packet tells the host that the transfer is over. The data toggle normally advances only on ACK. A forced-toggle mode advances it after every data packet whatever the host replied. A clear strobe returns the toggle to DATA0. PHY, CRC, isochronous behaviour and DMA sit outside the block.

The controller has three states. `ST_IDLE` accepts tokens. `ST_SEND` streams packet bytes. `ST_WAIT` waits for the handshake. The transitions are:
- `ST_IDLE -> ST_SEND` on a data response with a non-zero length.
- `ST_IDLE -> ST_WAIT` on a data response with zero length.
- `ST_SEND -> ST_WAIT` on the last byte.
- `ST_WAIT -> ST_IDLE` on ACK or on timeout.

NAK and STALL responses leave the state at `ST_IDLE`.

Top module: `ep_in_tx`

## Requirements
- R1: After reset there is no response, no byte on the data stream, the stall-sent flag and irq are low, and the first data packet of the first transfer is tagged DATA0.
- R2: An IN token taken in `ST_IDLE` while send_stall is high is answered with rsp_code 1 (STALL), rsp_len 0 and no data bytes, even when a packet is loaded. rsp_valid is high for one cycle in the cycle after the token.
- R3: Sending a STALL sets stall_sent. irq is high whenever stall_sent and irq_en are both high. A stall_clr pulse clears stall_sent, and a STALL sent in the same cycle wins over the clear.
- R4: An IN token taken in `ST_IDLE` with send_stall low, when no transfer is active or the FIFO holds fewer bytes than the current packet needs, is answered with rsp_code 0 (NAK) and no data bytes.
- R5: A data response carries rsp_code 2 (DATA0) or 3 (DATA1) and the packet length in rsp_len. Its bytes appear on tx_data one per cycle in FIFO write order, starting in the same cycle as rsp_valid, and tx_last marks the final byte.
- R6: A transfer is sent as packets of max_pkt bytes while at least max_pkt bytes remain. The remainder then goes out as one shorter packet, and no data packet is longer than max_pkt.
- R7: When the transfer length is an exact multiple of max_pkt, including zero, a zero-length data packet is sent last. xfer_done pulses for one cycle after the ACK of a packet shorter than max_pkt, and this ends the transfer.
- R8: With force_toggle low, the toggle flips only on an ACK. After a handshake timeout, the next IN token resends the same bytes with the same length and the same PID.
- R9: With force_toggle high, the toggle flips after every data packet's handshake, ACK or timeout. The FIFO data still advances only on ACK.
- R10: A toggle_clr pulse makes the next data packet DATA0, and it wins over a flip in the same cycle.
- R11: IN tokens arriving in `ST_SEND` or `ST_WAIT` get no response. xfer_start is ignored while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_wr_en | input | 1 | Push one payload byte (dropped when the FIFO is full) |
| fifo_wr_data | input | 8 | Payload byte |
| xfer_start | input | 1 | Start a transfer using xfer_len and max_pkt |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| max_pkt | input | PKT_W | Maximum packet size in bytes (non-zero, at most DEPTH) |
| send_stall | input | 1 | Halt the endpoint: answer tokens with STALL |
| force_toggle | input | 1 | Flip the toggle after every data packet |
| toggle_clr | input | 1 | Reset the toggle to DATA0 |
| stall_clr | input | 1 | Clear the stall-sent flag |
| irq_en | input | 1 | Endpoint interrupt enable |
| in_token | input | 1 | IN token received for this endpoint |
| hs_ack | input | 1 | Host ACK received |
| hs_timeout | input | 1 | No handshake came back |
| rsp_valid | output | 1 | Response issued this cycle |
| rsp_code | output | 2 | 0 NAK, 1 STALL, 2 DATA0, 3 DATA1 |
| rsp_len | output | PKT_W | Data packet length (0 for NAK, STALL and empty packets) |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final byte of the packet |
| stall_sent | output | 1 | Sticky flag: a STALL was sent |
| irq | output | 1 | Endpoint interrupt request |
| xfer_done | output | 1 | One-cycle pulse: the transfer has completed |

## Verification
The bound checker watches, on every cycle, the local rules of the response path:
- STALL precedence over data, and the stall flag together with its interrupt.
- The silence after a NAK, and a data response starting its byte stream at once.
- The packet-size ceiling and the toggle's hold, flip and clear rules around the handshake.
- The absence of responses while a packet is in flight.

Properties of a whole transfer can only be shown by the bench's scenarios, because they span many tokens and depend on the count of bytes committed:
- The sequence of packet lengths, including the closing empty packet.
- Byte order and retransmission of identical bytes after a timeout.
- The moment xfer_done fires.
- The rejection of a second start.

// File: rtl/ep_in_pkg.sv
package ep_in_pkg;

    typedef enum logic [1:0] {
        RSP_NAK   = 2'd0,
        RSP_STALL = 2'd1,
        RSP_DATA0 = 2'd2,
        RSP_DATA1 = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } st_e;

endpackage

// File: rtl/ep_in_fifo.sv
// Payload store with a committed base pointer so that an unacknowledged
// packet can be replayed from its first byte.
module ep_in_fifo #(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_adv,
    input  logic             commit,
    input  logic             rewind,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] level
);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] wr_p, rd_p, base_p;
    logic             full, push;

    assign level   = wr_p - base_p;
    assign full    = (level == CNT_W'(DEPTH));
    assign push    = wr_en && !full;
    assign rd_data = mem[rd_p[ADDR_W-1:0]];

    always_ff @(posedge clk) begin
        if (push) mem[wr_p[ADDR_W-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_p   <= '0;
            rd_p   <= '0;
            base_p <= '0;
        end else begin
            if (push) wr_p <= wr_p + CNT_W'(1);
            if (rewind)      rd_p <= base_p;
            else if (rd_adv) rd_p <= rd_p + CNT_W'(1);
            if (commit) base_p <= rd_p;
        end
    end

endmodule

// File: rtl/ep_in_seg.sv
// Transfer segmentation: remaining byte count, current packet size and the
// short-packet end condition.
module ep_in_seg #(
    parameter int LEN_W = 16,
    parameter int PKT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [PKT_W-1:0] max_pkt,
    input  logic             ack,
    output logic             active,
    output logic [PKT_W-1:0] cur_len,
    output logic [PKT_W-1:0] max_q,
    output logic             done
);

    logic [LEN_W-1:0] rem_q;
    logic             short_pkt;

    assign short_pkt = rem_q < LEN_W'(max_q);
    assign cur_len   = short_pkt ? rem_q[PKT_W-1:0] : max_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            max_q  <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    rem_q  <= xfer_len;
                    max_q  <= max_pkt;
                end
            end else if (ack) begin
                rem_q <= rem_q - LEN_W'(cur_len);
                if (short_pkt) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ep_in_tog.sv
// Data toggle: flips on ACK, or on any handshake outcome in forced mode.
module ep_in_tog (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ack,
    input  logic miss,
    input  logic force_flip,
    output logic tog
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       tog <= 1'b0;
        else if (clr)                     tog <= 1'b0;
        else if (ack || (miss && force_flip)) tog <= ~tog;
    end

endmodule

// File: rtl/ep_in_tx.sv
module ep_in_tx
    import ep_in_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = 16,
    parameter int PKT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_wr_en,
    input  logic [7:0]       fifo_wr_data,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [PKT_W-1:0] max_pkt,
    input  logic             send_stall,
    input  logic             force_toggle,
    input  logic             toggle_clr,
    input  logic             stall_clr,
    input  logic             irq_en,
    input  logic             in_token,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [PKT_W-1:0] rsp_len,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             stall_sent,
    output logic             irq,
    output logic             xfer_done
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    st_e              st_q, st_d;
    logic [PKT_W-1:0] byte_cnt;
    logic [PKT_W-1:0] cur_len, max_q;
    logic [CNT_W-1:0] level;
    logic             active, tog_q;
    logic             pkt_ready, tok_idle;
    logic             take_stall, take_data, take_nak;
    logic             ack_w, miss_w, rd_adv;
    rsp_e             rsp_code_q;

    ep_in_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr_en),
        .wr_data (fifo_wr_data),
        .rd_adv  (rd_adv),
        .commit  (ack_w),
        .rewind  (miss_w),
        .rd_data (tx_data),
        .level   (level)
    );

    ep_in_seg #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .xfer_len (xfer_len),
        .max_pkt  (max_pkt),
        .ack      (ack_w),
        .active   (active),
        .cur_len  (cur_len),
        .max_q    (max_q),
        .done     (xfer_done)
    );

    ep_in_tog u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (toggle_clr),
        .ack        (ack_w),
        .miss       (miss_w),
        .force_flip (force_toggle),
        .tog        (tog_q)
    );

    // token decode in the idle state; stall has priority over data
    assign tok_idle   = (st_q == ST_IDLE) && in_token;
    assign pkt_ready  = active && (int'(level) >= int'(cur_len));
    assign take_stall = tok_idle && send_stall;
    assign take_data  = tok_idle && !send_stall && pkt_ready;
    assign take_nak   = tok_idle && !send_stall && !pkt_ready;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (take_data) st_d = (cur_len == '0) ? ST_WAIT : ST_SEND;
            ST_SEND: if (tx_last) st_d = ST_WAIT;
            ST_WAIT: if (hs_ack || hs_timeout) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            byte_cnt <= '0;
        end else begin
            st_q <= st_d;
            if (take_data)            byte_cnt <= '0;
            else if (st_q == ST_SEND) byte_cnt <= byte_cnt + PKT_W'(1);
        end
    end

    // outputs decoded from the state
    always_comb begin
        tx_valid = (st_q == ST_SEND);
        tx_last  = (st_q == ST_SEND) && (byte_cnt == rsp_len - PKT_W'(1));
        rd_adv   = (st_q == ST_SEND);
        ack_w    = (st_q == ST_WAIT) && hs_ack;
        miss_w   = (st_q == ST_WAIT) && hs_timeout && !hs_ack;
        irq      = stall_sent && irq_en;
        rsp_code = rsp_code_q;
    end

    // registered response and stall status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code_q <= RSP_NAK;
            rsp_len    <= '0;
            stall_sent <= 1'b0;
        end else begin
            rsp_valid <= take_stall || take_data || take_nak;
            if (take_stall) begin
                rsp_code_q <= RSP_STALL;
                rsp_len    <= '0;
            end else if (take_data) begin
                rsp_code_q <= tog_q ? RSP_DATA1 : RSP_DATA0;
                rsp_len    <= cur_len;
            end else if (take_nak) begin
                rsp_code_q <= RSP_NAK;
                rsp_len    <= '0;
            end
            if (take_stall)     stall_sent <= 1'b1;
            else if (stall_clr) stall_sent <= 1'b0;
        end
    end

endmodule

// File: rtl/ep_in_tx_chk.sv
module ep_in_tx_chk
    import ep_in_pkg::*;
#(
    parameter int PKT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input st_e              st,
    input logic             in_token,
    input logic             send_stall,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [PKT_W-1:0] rsp_len,
    input logic [PKT_W-1:0] max_q,
    input logic             tx_valid,
    input logic             tog,
    input logic             hs_ack,
    input logic             hs_timeout,
    input logic             force_toggle,
    input logic             toggle_clr,
    input logic             stall_sent,
    input logic             irq_en,
    input logic             irq
);

    p_stall_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_token && send_stall) |=> (rsp_valid && rsp_code == RSP_STALL));

    p_stall_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_STALL) |-> stall_sent);

    p_stall_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_STALL && irq_en) |-> irq);

    p_nak_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_NAK) |-> !tx_valid);

    p_data_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code[1] && rsp_len != '0) |-> tx_valid);

    p_pkt_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code[1]) |-> (rsp_len <= max_q));

    p_pid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && hs_timeout && !hs_ack && !force_toggle && !toggle_clr) |=> $stable(tog));

    p_force_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && (hs_ack || hs_timeout) && force_toggle && !toggle_clr) |=> (tog != $past(tog)));

    p_tog_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_clr |=> !tog);

    p_busy_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> !rsp_valid);

endmodule

bind ep_in_tx ep_in_tx_chk #(.PKT_W(PKT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st_q),
    .in_token     (in_token),
    .send_stall   (send_stall),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_len      (rsp_len),
    .max_q        (max_q),
    .tx_valid     (tx_valid),
    .tog          (tog_q),
    .hs_ack       (hs_ack),
    .hs_timeout   (hs_timeout),
    .force_toggle (force_toggle),
    .toggle_clr   (toggle_clr),
    .stall_sent   (stall_sent),
    .irq_en       (irq_en),
    .irq          (irq)
);

// File: tb/ep_in_tx_tb_top.sv
`timescale 1ns/1ps
module ep_in_tx_tb_top;

    localparam int DEPTH = 64;
    localparam int LEN_W = 16;
    localparam int PKT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_wr_en = 0, xfer_start = 0, send_stall = 0, force_toggle = 0;
    logic             toggle_clr = 0, stall_clr = 0, irq_en = 0, in_token = 0;
    logic             hs_ack = 0, hs_timeout = 0;
    logic [7:0]       fifo_wr_data = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [PKT_W-1:0] max_pkt = '0;
    logic             rsp_valid, tx_valid, tx_last, stall_sent, irq, xfer_done;
    logic [1:0]       rsp_code;
    logic [PKT_W-1:0] rsp_len;
    logic [7:0]       tx_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    ep_in_tx #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PKT_W(PKT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .xfer_start(xfer_start), .xfer_len(xfer_len), .max_pkt(max_pkt),
        .send_stall(send_stall), .force_toggle(force_toggle),
        .toggle_clr(toggle_clr), .stall_clr(stall_clr), .irq_en(irq_en),
        .in_token(in_token), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .stall_sent(stall_sent), .irq(irq), .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_q[$];
    int m_state, m_cnt, m_len, m_code, m_rem, m_max;
    bit m_rsp_v, m_active, m_tog, m_stall, m_done;
    int cur;
    bit act0, wr_ok, stall_set;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete();
            m_state = 0; m_cnt = 0; m_len = 0; m_code = 0; m_rem = 0; m_max = 0;
            m_rsp_v = 0; m_active = 0; m_tog = 0; m_stall = 0; m_done = 0;
        end else begin
            act0 = m_active;
            wr_ok = fifo_wr_en && (m_q.size() < DEPTH);
            cur = (m_rem < m_max) ? m_rem : m_max;
            m_rsp_v = 0; m_done = 0; stall_set = 0;
            case (m_state)
                0: if (in_token) begin
                    m_rsp_v = 1;
                    if (send_stall) begin
                        m_code = 1; m_len = 0; stall_set = 1;
                    end else if (m_active && m_q.size() >= cur) begin
                        m_code = m_tog ? 3 : 2; m_len = cur; m_cnt = 0;
                        m_state = (cur > 0) ? 1 : 2;
                    end else begin
                        m_code = 0; m_len = 0;
                    end
                end
                1: begin
                    if (m_cnt == m_len - 1) m_state = 2;
                    m_cnt++;
                end
                default: if (hs_ack) begin
                    for (int n = 0; n < m_len; n++) void'(m_q.pop_front());
                    m_rem -= m_len;
                    if (m_len < m_max) begin m_active = 0; m_done = 1; end
                    m_tog = !m_tog;
                    m_state = 0;
                end else if (hs_timeout) begin
                    if (force_toggle) m_tog = !m_tog;
                    m_state = 0;
                end
            endcase
            if (xfer_start && !act0) begin
                m_active = 1; m_rem = int'(xfer_len); m_max = int'(max_pkt);
            end
            if (toggle_clr) m_tog = 0;
            if (stall_set) m_stall = 1;
            else if (stall_clr) m_stall = 0;
            if (wr_ok) m_q.push_back(fifo_wr_data);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R4", "rsp_valid", int'(rsp_valid), int'(m_rsp_v));
            if (m_rsp_v) begin
                chk("R8", "rsp_code", int'(rsp_code), m_code);
                chk("R6", "rsp_len", int'(rsp_len), m_len);
            end
            chk("R5", "tx_valid", int'(tx_valid), int'(m_state == 1));
            if (m_state == 1) begin
                chk("R5", "tx_data", int'(tx_data), int'(m_q[m_cnt]));
                chk("R5", "tx_last", int'(tx_last), int'(m_cnt == m_len - 1));
            end
            chk("R3", "stall_sent", int'(stall_sent), int'(m_stall));
            chk("R3", "irq", int'(irq), int'(m_stall && irq_en));
            chk("R7", "xfer_done", int'(xfer_done), int'(m_done));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic push_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            fifo_wr_en = 1; fifo_wr_data = 8'(seed + i); cyc(1);
        end
        fifo_wr_en = 0;
    endtask

    task automatic begin_xfer(input int len, input int mp);
        xfer_start = 1; xfer_len = LEN_W'(len); max_pkt = PKT_W'(mp);
        cyc(1);
        xfer_start = 0;
    endtask

    task automatic token(output int code, output int len);
        in_token = 1; cyc(1); in_token = 0;
        code = int'(rsp_code); len = int'(rsp_len);
    endtask

    task automatic handshake(input bit ack);
        if (ack) hs_ack = 1; else hs_timeout = 1;
        cyc(1);
        hs_ack = 0; hs_timeout = 0;
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        int c, l, c1, l1;
        cyc(3);
        chk("R1", "reset rsp_valid", int'(rsp_valid), 0);
        chk("R1", "reset tx_valid", int'(tx_valid), 0);
        chk("R1", "reset stall_sent", int'(stall_sent), 0);
        chk("R1", "reset irq", int'(irq), 0);
        rst_n = 1;
        cyc(2);

        // R4: no transfer active
        token(c, l);
        chk("R4", "nak without transfer", c, 0);

        // 10 bytes, max 4: 4,4,2
        begin_xfer(10, 4);
        token(c, l);
        chk("R4", "nak when fifo short", c, 0);
        push_bytes(10, 8'h30);
        token(c, l);
        chk("R1", "first pid is DATA0", c, 2);
        chk("R6", "first packet full size", l, 4);
        chk("R5", "first byte", int'(tx_data), 8'h30);
        in_token = 1; cyc(1); in_token = 0;
        chk("R11", "token while sending ignored", int'(rsp_valid), 0);
        cyc(l - 1);
        handshake(1);
        token(c, l);
        chk("R8", "pid after ack DATA1", c, 3);
        chk("R6", "second packet full", l, 4);
        cyc(l);
        handshake(0);
        token(c1, l1);
        chk("R8", "resend same pid", c1, c);
        chk("R8", "resend same length", l1, l);
        chk("R8", "resend same first byte", int'(tx_data), 8'h34);
        cyc(l1);
        handshake(1);
        token(c, l);
        chk("R6", "remainder packet", l, 2);
        cyc(l);
        handshake(1);
        chk("R7", "done after short packet", int'(xfer_done), 1);
        token(c, l);
        chk("R4", "nak after transfer end", c, 0);

        // exact multiple: 8 bytes, max 4 -> 4,4,0
        push_bytes(8, 8'h50);
        begin_xfer(8, 4);
        token(c, l);
        chk("R6", "multiple first packet", l, 4);
        cyc(l);
        handshake(1);
        begin_xfer(3, 2);                 // ignored: transfer active
        token(c, l);
        chk("R11", "second start ignored", l, 4);
        cyc(l);
        handshake(1);
        chk("R7", "no done after full packet", int'(xfer_done), 0);
        token(c, l);
        chk("R7", "closing empty packet data", c / 2, 1);
        chk("R7", "closing empty packet len", l, 0);
        chk("R7", "empty packet no bytes", int'(tx_valid), 0);
        handshake(1);
        chk("R7", "done after empty packet", int'(xfer_done), 1);

        // zero-length transfer
        begin_xfer(0, 8);
        token(c, l);
        chk("R7", "zero transfer empty packet", l, 0);
        handshake(1);
        chk("R7", "zero transfer done", int'(xfer_done), 1);

        // forced toggle
        force_toggle = 1;
        push_bytes(6, 8'h70);
        begin_xfer(6, 8);
        token(c, l);
        cyc(l);
        handshake(0);
        token(c1, l1);
        chk("R9", "forced flip on timeout", int'(c1 != c), 1);
        chk("R9", "data not advanced", int'(tx_data), 8'h70);
        chk("R9", "same length", l1, 6);
        cyc(l1);
        handshake(1);
        chk("R9", "done after forced ack", int'(xfer_done), 1);
        force_toggle = 0;

        // stall and toggle clear
        push_bytes(3, 8'h90);
        begin_xfer(3, 4);
        send_stall = 1;
        token(c, l);
        chk("R2", "stall despite data", c, 1);
        chk("R2", "stall len", l, 0);
        chk("R3", "stall flag set", int'(stall_sent), 1);
        chk("R3", "irq masked", int'(irq), 0);
        irq_en = 1; #1;
        chk("R3", "irq enabled", int'(irq), 1);
        cyc(1);
        chk("R2", "no bytes after stall", int'(tx_valid), 0);
        stall_clr = 1; cyc(1); stall_clr = 0;
        chk("R3", "stall flag cleared", int'(stall_sent), 0);
        chk("R3", "irq cleared", int'(irq), 0);
        send_stall = 0;
        toggle_clr = 1; cyc(1); toggle_clr = 0;
        token(c, l);
        chk("R10", "DATA0 after clear", c, 2);
        cyc(l);
        toggle_clr = 1;
        handshake(1);
        toggle_clr = 0;
        chk("R7", "done after stall test", int'(xfer_done), 1);
        push_bytes(2, 8'hA0);
        begin_xfer(2, 4);
        token(c, l);
        chk("R10", "clear wins over ack flip", c, 2);
        cyc(l);
        handshake(1);
        cyc(2);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired R1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule